// File: doc/BRIEF.md
# 8b/10b Line Encoder with Per-Character Disparity Override

This block turns one byte and a control flag into a 10-bit line code group for a serial transmitter. In normal use it keeps its own running disparity and picks each code group variant from that state, so the long-run count of ones and zeros on the line stays balanced. Each code group is built from a 6-bit sub-block for the low five data bits and a 4-bit sub-block for the high three. The 4-bit sub-block sees the disparity that the 6-bit sub-block leaves behind.

A link layer that must send training patterns with a known disparity can set a force bit on any character. The force bit ignores the tracked disparity. A second bit then chooses the variant directly: 0 picks the variant used when the current disparity is negative, and 1 picks the variant used when it is positive. After every character the tracked disparity is rebuilt from the group that was actually sent. Bit 0 of the parallel output is the first bit placed on the serial line.

Top module: `enc8b10b_ovr`

## Requirements
- R1: While `rst_n` is low at a clock edge, the encoder clears `out_code` to 0, `out_kerr` to 0 and `out_rd` to 0. `out_rd` = 0 means negative disparity and 1 means positive.
- R2: Outputs change only on the clock edge that samples `in_valid` high, so they update one cycle later. They hold their values while `in_valid` is low.
- R3: With `frc_en` = 0, the data byte (x = bits 4:0, y = bits 7:5) is encoded with the standard 5b/6b and 3b/4b tables. The 6-bit sub-block variant comes from the tracked disparity. The 4-bit variant comes from the disparity left after the 6-bit sub-block. `out_code` bits 0..9 carry a,b,c,d,e,i,f,g,h,j, with bit 0 sent first.
- R4: With `frc_en` = 1 and `frc_pos` = 0, the negative-disparity variant is sent whatever the tracked state is. For K28.5 (byte 0xBC, control) `out_code` is 10'h17C, which is 0011111010 written first-bit-left.
- R5: With `frc_en` = 1 and `frc_pos` = 1, the positive-disparity variant is sent. For K28.5 `out_code` is 10'h283, which is 1100000101 written first-bit-left.
- R6: A balanced character whose two variants match encodes the same way under both force values. For D17.1 (byte 0x31, data) `out_code` is 10'h271, which is 1000111001 written first-bit-left.
- R7: After every character, forced or not, `out_rd` follows the group that was sent. It becomes 1 if the group has six ones and 0 if it has four. If the group has five ones, `out_rd` takes the disparity used to choose the variant: `frc_pos` when forced, otherwise the tracked value.
- R8: D.x.7 uses the alternate 0111/1000 3b/4b form in two cases: x is 17, 18 or 20 with negative disparity after the 6-bit sub-block, or x is 11, 13 or 14 with positive disparity. Examples: D17.7 forced negative gives 10'h3B1, and D11.7 forced positive gives 10'h04B.
- R9: If the control flag is set with a byte that is not one of the twelve legal control characters, `out_kerr` goes to 1 and the byte is encoded as data. The legal control characters are K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7. A legal control character clears `out_kerr`.
- R10: The K28 characters use the 6-bit group 001111/110000 and the control 3b/4b forms. K23.7, K27.7, K29.7 and K30.7 use the data 6-bit group and the alternate 0111/1000 4-bit form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A character is presented this cycle |
| in_byte | input | 8 | Byte to encode (bits 4:0 = x, bits 7:5 = y) |
| in_ctrl | input | 1 | Encode the byte as a control character |
| frc_en | input | 1 | Ignore the tracked disparity for this character |
| frc_pos | input | 1 | When forcing: 0 = negative-disparity variant, 1 = positive |
| out_code | output | 10 | Code group; bit 0 is sent first |
| out_rd | output | 1 | Running disparity after the last character (1 = positive) |
| out_kerr | output | 1 | Last character was an illegal control request |

## Verification
The bench checks the override mapping against fixed code groups for K28.5 and D17.1. A design with the meaning of the force value swapped, or with the output bit order reversed, fails these literal checks at once. Forced characters are interleaved with tracked ones, and balanced forced groups are included. This catches a tracker that ignores what was forced, or that keeps its old state after a forced balanced group. The D.x.7 cases sit on both sides of the alternate-form condition. Those cases, every data byte in both disparity states, the twelve legal control codes and several illegal ones expose a wrong 4-bit disparity source, a wrong alternate-form rule or a missing error flag.

// File: rtl/enc8b10b_pkg.sv
// Shared constants for the 8b/10b encoder.
// Assumes the standard split of a byte into a 5-bit low part (x) and a
// 3-bit high part (y).
package enc8b10b_pkg;
    localparam int BYTE_W  = 8;
    localparam int X_W     = 5;
    localparam int Y_W     = BYTE_W - X_W;
    localparam int SIX_W   = 6;
    localparam int FOUR_W  = 4;
    localparam int CODE_W  = SIX_W + FOUR_W;
    localparam int BAL_SIX  = SIX_W / 2;
    localparam int BAL_FOUR = FOUR_W / 2;
    localparam int BAL_CODE = CODE_W / 2;
    localparam logic [X_W-1:0] X_K28 = 5'd28;
    localparam logic [Y_W-1:0] Y_SEVEN = 3'd7;
endpackage

// File: rtl/enc_kcheck.sv
// Decides whether a control request names one of the twelve legal control
// characters. Assumes x = byte[4:0] and y = byte[7:5].
module enc_kcheck
    import enc8b10b_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              ctrl_in,
    output logic              k_legal,
    output logic              k_is28
);
    logic [X_W-1:0] x_v;
    logic [Y_W-1:0] y_v;
    assign x_v = byte_in[X_W-1:0];
    assign y_v = byte_in[BYTE_W-1:X_W];

    // Classify the request against the legal control set.
    always_comb begin
        k_is28  = ctrl_in && (x_v == X_K28);
        k_legal = k_is28;
        if (ctrl_in && (y_v == Y_SEVEN) &&
            (x_v == 5'd23 || x_v == 5'd27 || x_v == 5'd29 || x_v == 5'd30))
            k_legal = 1'b1;
    end
endmodule

// File: rtl/enc_six.sv
// 5b/6b sub-block encoder. Output is written a,b,c,d,e,i from MSB to LSB.
// Assumes rd_in = 1 means positive disparity. Reports the disparity left
// after this sub-block.
module enc_six
    import enc8b10b_pkg::*;
(
    input  logic [X_W-1:0]   x_in,
    input  logic             k28,
    input  logic             rd_in,
    output logic [SIX_W-1:0] six_out,
    output logic             rd_mid
);
    logic [SIX_W-1:0] neg_form;
    logic             flip_col;

    // Negative-column code for each low part.
    always_comb begin
        case (x_in)
            5'd0:  neg_form = 6'b100111;
            5'd1:  neg_form = 6'b011101;
            5'd2:  neg_form = 6'b101101;
            5'd3:  neg_form = 6'b110001;
            5'd4:  neg_form = 6'b110101;
            5'd5:  neg_form = 6'b101001;
            5'd6:  neg_form = 6'b011001;
            5'd7:  neg_form = 6'b111000;
            5'd8:  neg_form = 6'b111001;
            5'd9:  neg_form = 6'b100101;
            5'd10: neg_form = 6'b010101;
            5'd11: neg_form = 6'b110100;
            5'd12: neg_form = 6'b001101;
            5'd13: neg_form = 6'b101100;
            5'd14: neg_form = 6'b011100;
            5'd15: neg_form = 6'b010111;
            5'd16: neg_form = 6'b011011;
            5'd17: neg_form = 6'b100011;
            5'd18: neg_form = 6'b010011;
            5'd19: neg_form = 6'b110010;
            5'd20: neg_form = 6'b001011;
            5'd21: neg_form = 6'b101010;
            5'd22: neg_form = 6'b011010;
            5'd23: neg_form = 6'b111010;
            5'd24: neg_form = 6'b110011;
            5'd25: neg_form = 6'b100110;
            5'd26: neg_form = 6'b010110;
            5'd27: neg_form = 6'b110110;
            5'd28: neg_form = 6'b001110;
            5'd29: neg_form = 6'b101110;
            5'd30: neg_form = 6'b011110;
            default: neg_form = 6'b101011;
        endcase
        if (k28)
            neg_form = 6'b001111;
    end

    // Choose the column and work out the disparity left behind.
    always_comb begin
        flip_col = ($countones(neg_form) != BAL_SIX) ||
                   (!k28 && x_in == 5'd7);
        six_out  = (rd_in && flip_col) ? ~neg_form : neg_form;
        rd_mid   = ($countones(six_out) == BAL_SIX) ? rd_in
                                                    : ($countones(six_out) > BAL_SIX);
    end
endmodule

// File: rtl/enc_four.sv
// 3b/4b sub-block encoder. Output is written f,g,h,j from MSB to LSB.
// Assumes rd_in is the disparity after the 6-bit sub-block. Handles the
// alternate x.7 form and the K28 forms.
module enc_four
    import enc8b10b_pkg::*;
(
    input  logic [Y_W-1:0]    y_in,
    input  logic [X_W-1:0]    x_in,
    input  logic              k_any,
    input  logic              k28,
    input  logic              rd_in,
    output logic [FOUR_W-1:0] four_out
);
    logic [FOUR_W-1:0] neg_form;
    logic              use_alt;
    logic              flip_col;

    // Decide whether x.7 must take the alternate form to limit run length.
    always_comb begin
        use_alt = 1'b0;
        if (y_in == Y_SEVEN) begin
            if (k_any)
                use_alt = 1'b1;
            else if (!rd_in && (x_in == 5'd17 || x_in == 5'd18 || x_in == 5'd20))
                use_alt = 1'b1;
            else if (rd_in && (x_in == 5'd11 || x_in == 5'd13 || x_in == 5'd14))
                use_alt = 1'b1;
        end
    end

    // Negative-column code, then column choice.
    always_comb begin
        if (k28) begin
            case (y_in)
                3'd0: neg_form = 4'b1011;
                3'd1: neg_form = 4'b0110;
                3'd2: neg_form = 4'b1010;
                3'd3: neg_form = 4'b1100;
                3'd4: neg_form = 4'b1101;
                3'd5: neg_form = 4'b0101;
                3'd6: neg_form = 4'b1001;
                default: neg_form = 4'b0111;
            endcase
            flip_col = 1'b1;
        end else begin
            case (y_in)
                3'd0: neg_form = 4'b1011;
                3'd1: neg_form = 4'b1001;
                3'd2: neg_form = 4'b0101;
                3'd3: neg_form = 4'b1100;
                3'd4: neg_form = 4'b1101;
                3'd5: neg_form = 4'b1010;
                3'd6: neg_form = 4'b0110;
                default: neg_form = use_alt ? 4'b0111 : 4'b1110;
            endcase
            flip_col = ($countones(neg_form) != BAL_FOUR) || (y_in == 3'd3);
        end
        four_out = (rd_in && flip_col) ? ~neg_form : neg_form;
    end
endmodule

// File: rtl/enc8b10b_ovr.sv
// 8b/10b encoder with a per-character disparity override.
// Assumes one character per cycle, qualified by in_valid. Output bit 0 is
// the first serial bit. The running disparity is rebuilt from each
// emitted group.
module enc8b10b_ovr
    import enc8b10b_pkg::*;
#(
    parameter logic RESET_RD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_ctrl,
    input  logic              frc_en,
    input  logic              frc_pos,
    output logic [CODE_W-1:0] out_code,
    output logic              out_rd,
    output logic              out_kerr
);
    logic              rd_q;
    logic              rd_sel;
    logic              rd_mid;
    logic              k_legal;
    logic              k_is28;
    logic              k28_eff;
    logic [SIX_W-1:0]  six_w;
    logic [FOUR_W-1:0] four_w;
    logic [CODE_W-1:0] written;
    logic [CODE_W-1:0] code_nx;
    logic              rd_nx;

    // Disparity used to pick this character's variant.
    assign rd_sel  = frc_en ? frc_pos : rd_q;
    assign k28_eff = k_is28 && k_legal;

    enc_kcheck u_kchk (
        .byte_in (in_byte),
        .ctrl_in (in_ctrl),
        .k_legal (k_legal),
        .k_is28  (k_is28)
    );

    enc_six u_six (
        .x_in    (in_byte[X_W-1:0]),
        .k28     (k28_eff),
        .rd_in   (rd_sel),
        .six_out (six_w),
        .rd_mid  (rd_mid)
    );

    enc_four u_four (
        .y_in     (in_byte[BYTE_W-1:X_W]),
        .x_in     (in_byte[X_W-1:0]),
        .k_any    (k_legal),
        .k28      (k28_eff),
        .rd_in    (rd_mid),
        .four_out (four_w)
    );

    assign written = {six_w, four_w};

    // Put the first-sent bit (written MSB) at output bit 0.
    for (genvar gi = 0; gi < CODE_W; gi++) begin : g_rev
        assign code_nx[gi] = written[CODE_W-1-gi];
    end

    // Next disparity from the group actually emitted.
    assign rd_nx = ($countones(code_nx) == BAL_CODE) ? rd_sel
                                                     : ($countones(code_nx) > BAL_CODE);

    // Register the code group, disparity and error flag on each valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_code <= '0;
            out_kerr <= 1'b0;
            rd_q     <= RESET_RD;
        end else if (in_valid) begin
            out_code <= code_nx;
            out_kerr <= in_ctrl && !k_legal;
            rd_q     <= rd_nx;
        end
    end

    assign out_rd = rd_q;

    // Outputs hold while no character is presented.
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_code) && $stable(out_rd) && $stable(out_kerr)));

    // Every emitted group has four, five or six ones.
    p_group_weight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($countones(out_code) >= 4 && $countones(out_code) <= 6));

    // Disparity follows the sign of an unbalanced group.
    p_rd_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($countones(out_code) == BAL_CODE ||
                      out_rd == ($countones(out_code) > BAL_CODE)));

    // A forced balanced group leaves the forced disparity.
    p_forced_bal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frc_en) |=> ($countones(out_code) != BAL_CODE ||
                                  out_rd == $past(frc_pos)));

    // K28.5 is always a legal control character.
    p_k285_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ctrl && in_byte == 8'hBC) |=> !out_kerr);
endmodule

// File: tb/enc8b10b_ovr_test.sv
module enc8b10b_ovr_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ctrl = 1'b0;
    logic       frc_en = 1'b0;
    logic       frc_pos = 1'b0;
    logic [9:0] out_code;
    logic       out_rd;
    logic       out_kerr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [9:0] exp_code = '0;
    logic       exp_rd = 1'b0;
    logic       exp_kerr = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    enc8b10b_ovr uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ctrl(in_ctrl), .frc_en(frc_en), .frc_pos(frc_pos),
        .out_code(out_code), .out_rd(out_rd), .out_kerr(out_kerr)
    );

    function automatic logic [5:0] tb_six(input int x);
        logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
            6'b110101, 6'b101001, 6'b011001, 6'b111000, 6'b111001, 6'b100101,
            6'b010101, 6'b110100, 6'b001101, 6'b101100, 6'b011100, 6'b010111,
            6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010,
            6'b011010, 6'b111010, 6'b110011, 6'b100110, 6'b010110, 6'b110110,
            6'b001110, 6'b101110, 6'b011110, 6'b101011};
        return t[x];
    endfunction

    function automatic int ones(input logic [9:0] v);
        int n = 0;
        for (int i = 0; i < 10; i++) n += v[i];
        return n;
    endfunction

    // Reference encoder: rd is -1 or +1; returns output-order code.
    function automatic logic [9:0] ref_enc(input logic [7:0] b, input bit k,
                                           input int rd, output bit kerr);
        int x = int'(b[4:0]);
        int y = int'(b[7:5]);
        bit legal = k && (x == 28 || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30)));
        bit is28 = legal && x == 28;
        logic [5:0] s;
        logic [3:0] f;
        logic [3:0] fd [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
        logic [3:0] fk [8] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100, 4'b1101, 4'b0101, 4'b1001, 4'b0111};
        int rdm;
        logic [9:0] w;
        logic [9:0] o;
        kerr = k && !legal;
        s = is28 ? 6'b001111 : tb_six(x);
        if (rd > 0 && (ones({4'b0, s}) != 3 || (x == 7 && !is28))) s = ~s;
        rdm = (ones({4'b0, s}) == 3) ? rd : ((ones({4'b0, s}) > 3) ? 1 : -1);
        if (is28) begin
            f = fk[y];
            if (rdm > 0) f = ~f;
        end else begin
            f = fd[y];
            if (y == 7 && (legal || (rdm < 0 && (x == 17 || x == 18 || x == 20)) ||
                           (rdm > 0 && (x == 11 || x == 13 || x == 14))))
                f = 4'b0111;
            if (rdm > 0 && (ones({6'b0, f}) != 2 || y == 3)) f = ~f;
        end
        w = {s, f};
        for (int i = 0; i < 10; i++) o[i] = w[9-i];
        return o;
    endfunction

    task automatic check(input string tag);
        n_chk++;
        if (out_code !== exp_code || out_rd !== exp_rd || out_kerr !== exp_kerr) begin
            n_bad++;
            $display("FAIL %s: code=%h rd=%b kerr=%b expected code=%h rd=%b kerr=%b",
                     tag, out_code, out_rd, out_kerr, exp_code, exp_rd, exp_kerr);
        end
    endtask

    task automatic check_lit(input string tag, input logic [9:0] want);
        n_chk++;
        if (out_code !== want) begin
            n_bad++;
            $display("FAIL %s: code=%h expected %h", tag, out_code, want);
        end
    endtask

    // Drive at negedge, update the model at posedge, compare mid-cycle.
    task automatic step(input bit v, input logic [7:0] b, input bit k,
                        input bit fe, input bit fp, input string tag);
        bit ke;
        int rs;
        logic [9:0] c;
        in_valid = v; in_byte = b; in_ctrl = k; frc_en = fe; frc_pos = fp;
        @(posedge clk);
        if (v) begin
            rs = fe ? (fp ? 1 : -1) : (exp_rd ? 1 : -1);
            c = ref_enc(b, k, rs, ke);
            exp_code = c;
            exp_kerr = ke;
            exp_rd = (ones(c) == 5) ? (rs > 0) : (ones(c) > 5);
        end
        #(PERIOD/4);
        check(tag);
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        // R4 / R5: forced K28.5 variants.
        step(1, 8'hBC, 1, 1, 0, "R4 K28.5 forced negative");
        check_lit("R4 K28.5 literal", 10'h17C);
        step(1, 8'hBC, 1, 1, 1, "R5 K28.5 forced positive");
        check_lit("R5 K28.5 literal", 10'h283);
        // R6: neutral D17.1 under both force values.
        step(1, 8'h31, 0, 1, 0, "R6 D17.1 forced negative");
        check_lit("R6 D17.1 literal neg", 10'h271);
        step(1, 8'h31, 0, 1, 1, "R6 D17.1 forced positive");
        check_lit("R6 D17.1 literal pos", 10'h271);
        // R2: hold while idle.
        for (int i = 0; i < 3; i++) step(0, 8'hFF, 1, 1, 0, "R2 hold while idle");
        // R8: alternate x.7 forms.
        step(1, 8'hF1, 0, 1, 0, "R8 D17.7 negative");
        check_lit("R8 D17.7 literal", 10'h3B1);
        step(1, 8'hEB, 0, 1, 1, "R8 D11.7 positive");
        check_lit("R8 D11.7 literal", 10'h04B);
        step(1, 8'hF1, 0, 1, 1, "R8 D17.7 positive primary");
        step(1, 8'hEB, 0, 1, 0, "R8 D11.7 negative primary");
        // R3: every data byte from each starting disparity.
        for (int p = 0; p < 2; p++) begin
            step(1, 8'hBC, 1, 1, p[0], "R7 set disparity");
            for (int b = 0; b < 256; b++) step(1, b[7:0], 0, 0, 0, "R3 tracked data");
        end
        // R10: legal control characters, tracked and forced.
        for (int y = 0; y < 8; y++) begin
            step(1, {y[2:0], 5'd28}, 1, 0, 0, "R10 K28 tracked");
            step(1, {y[2:0], 5'd28}, 1, 1, y[0], "R10 K28 forced");
        end
        step(1, 8'hF7, 1, 0, 0, "R10 K23.7");
        step(1, 8'hFB, 1, 0, 0, "R10 K27.7");
        step(1, 8'hFD, 1, 0, 0, "R10 K29.7");
        step(1, 8'hFE, 1, 0, 0, "R10 K30.7");
        // R9: illegal control requests.
        step(1, 8'h17, 1, 0, 0, "R9 illegal K23.0");
        step(1, 8'hAA, 1, 0, 0, "R9 illegal K10.5");
        step(1, 8'hFF, 1, 1, 1, "R9 illegal K31.7 forced");
        step(1, 8'hBC, 1, 0, 0, "R9 legal clears error");
        // R7: mixed forced and tracked traffic.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            step(r[8], r[7:0], r[9] & r[10], r[11] & r[12], r[13], "R7 mixed traffic");
        end
        // R1: reset returns to the cleared state.
        rst_n = 1'b0;
        @(posedge clk);
        #(PERIOD/4);
        exp_code = '0; exp_rd = 1'b0; exp_kerr = 1'b0;
        check("R1 reset after traffic");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule